// File: doc/BRIEF.md
# Idle-Tick Dynamic Retention Controller

This block decides when a cache RAM subsystem has been quiet long enough to be put into a low-leakage retention state. It watches an idle indication from the subsystem and counts single-cycle pulses from a free-running timer tick input. Once the subsystem has stayed idle for a programmed number of ticks, the block raises a retention request. The power switching itself is handled elsewhere.

The number of ticks comes from a 3-bit selector on a non-linear scale, and code zero turns the function off. The selector may change at any time. A change restarts the wait using the new threshold. Any busy cycle drops the request at once and starts the count again from zero. The tick counter saturates and never wraps, so a request that has been granted stays up for as long as the subsystem remains idle.

Top module: `ret_idle_ctrl`

## Requirements
- R1: A selector value of 3'b000 disables the block: `ret_req_o` is low in every cycle in which `ret_sel_i` is 3'b000.
- R2: Selector values 3'b001, 3'b010 and 3'b011 set the idle threshold to 2, 8 and 32 ticks.
- R3: Selector values 3'b100, 3'b101, 3'b110 and 3'b111 set the idle threshold to 64, 128, 256 and 512 ticks.
- R4: In any cycle in which `idle_i` is low, `ret_req_o` is low in that same cycle, and the tick count restarts from zero.
- R5: Only clock edges at which `tick_i` is high advance the count. Idle cycles without a tick leave both the count and the request unchanged.
- R6: In a cycle in which `ret_sel_i` differs from its value in the previous cycle, `ret_req_o` is low and the count restarts from zero. Counting then uses the new threshold.
- R7: Once raised, `ret_req_o` stays high while `idle_i` stays high and `ret_sel_i` stays constant and non-zero. This holds even after more than 1023 ticks, because the count saturates instead of wrapping.
- R8: `ret_req_o` goes high in the cycle that follows the clock edge at which the tick bringing the count to the threshold is sampled, and at no earlier edge.
- R9: After the synchronous active-low reset, `ret_req_o` is low and the count is zero, so the full threshold of ticks is needed before a request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_i | input | 1 | High while the RAM subsystem is idle |
| tick_i | input | 1 | Single-cycle timer tick pulse |
| ret_sel_i | input | 3 | Threshold selector; 3'b000 disables the block |
| ret_req_o | output | 1 | Retention request |

## Verification
The bench builds the block with its default parameters: a 10-bit saturating counter and a 3-bit selector. At this width the 512-tick threshold can be reached, and a long idle run can push the counter into saturation within the cycle budget. Random phases with dense and sparse ticks sweep all eight selector codes. They also mix in rare busy cycles and mid-count selector changes. Directed runs check the shortest threshold at the exact tick and hold the request across more than 1023 ticks.

// File: rtl/ret_pkg.sv
// Package: shared widths and threshold encoding helpers for the retention controller.
// Assumes the selector is small (a few bits) and thresholds fit the counter width.
package ret_pkg;
    localparam int unsigned SEL_W = 3;
    localparam int unsigned CNT_W = 10;

    // Threshold for one selector code: 0 = off, 1..3 = 2^(2k-1), 4.. = 2^(k+2).
    function automatic int unsigned code_ticks(input int unsigned code);
        if (code == 0)
            return 0;
        else if (code < 4)
            return 32'd1 << (2 * code - 1);
        else
            return 32'd1 << (code + 2);
    endfunction
endpackage

// File: rtl/ret_thr_decode.sv
// Module: maps the selector code to a tick threshold through a table built at elaboration.
// Assumes every threshold fits in CNT_W bits; code 0 yields an enable flag of zero.
module ret_thr_decode #(
    parameter int unsigned SEL_W = ret_pkg::SEL_W,
    parameter int unsigned CNT_W = ret_pkg::CNT_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] thr_o,
    output logic             en_o
);
    localparam int unsigned CODES = 1 << SEL_W;

    logic [CNT_W-1:0] thr_tab [CODES];

    // One constant table entry per selector code.
    for (genvar g = 0; g < CODES; g++) begin : g_tab
        localparam int unsigned TICKS = ret_pkg::code_ticks(g);
        assign thr_tab[g] = CNT_W'(TICKS);
    end

    // Look up the threshold and flag whether the block is enabled.
    always_comb begin
        thr_o = thr_tab[sel_i];
        en_o  = (sel_i != '0);
    end
endmodule

// File: rtl/ret_sel_watch.sv
// Module: remembers the selector from the previous cycle and flags any change.
// Assumes a synchronous active-low reset; the stored value resets to the disabled code.
module ret_sel_watch #(
    parameter int unsigned SEL_W = ret_pkg::SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel_i,
    output logic             chg_o
);
    logic [SEL_W-1:0] sel_q;

    // Capture the selector every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_i;
    end

    // Report a change against the previous cycle.
    always_comb chg_o = (sel_i != sel_q);
endmodule

// File: rtl/ret_tick_cnt.sv
// Module: saturating tick counter with a synchronous clear.
// Assumes tick_i is a one-cycle pulse; a clear wins over a tick in the same cycle.
module ret_tick_cnt #(
    parameter int unsigned CNT_W = ret_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_nxt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Next count: clear, hold at the ceiling, or step on a tick.
    always_comb begin
        if (clr_i)
            cnt_nxt_o = '0;
        else if (tick_i && (cnt_q != CNT_MAX))
            cnt_nxt_o = cnt_q + CNT_W'(1);
        else
            cnt_nxt_o = cnt_q;
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_nxt_o;
    end
endmodule

// File: rtl/ret_idle_ctrl.sv
// Module: top of the retention controller. It counts timer ticks while the RAM is idle and
// requests retention once the count reaches the selected threshold.
// Assumes idle_i, tick_i and ret_sel_i are synchronous to clk.
module ret_idle_ctrl #(
    parameter int unsigned SEL_W = ret_pkg::SEL_W,
    parameter int unsigned CNT_W = ret_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] ret_sel_i,
    output logic             ret_req_o
);
    logic [CNT_W-1:0] thr;
    logic             en;
    logic             sel_chg;
    logic             clr;
    logic [CNT_W-1:0] cnt_nxt;
    logic             req_q;

    ret_thr_decode #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_dec (
        .sel_i (ret_sel_i),
        .thr_o (thr),
        .en_o  (en)
    );

    ret_sel_watch #(.SEL_W(SEL_W)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .sel_i (ret_sel_i),
        .chg_o (sel_chg)
    );

    // Any busy cycle, disabled selector or selector change restarts the wait.
    always_comb clr = !idle_i || !en || sel_chg;

    ret_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .tick_i    (tick_i),
        .cnt_nxt_o (cnt_nxt)
    );

    // Register the request once the new count meets the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= !clr && (cnt_nxt >= thr);
    end

    // Drop the request in the same cycle as any restart condition.
    always_comb ret_req_o = req_q && !clr;
endmodule

// File: rtl/ret_idle_ctrl_chk.sv
// Checker: port-level properties of the retention controller, attached by bind.
module ret_idle_ctrl_chk #(
    parameter int unsigned SEL_W = ret_pkg::SEL_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idle_i,
    input logic             tick_i,
    input logic [SEL_W-1:0] ret_sel_i,
    input logic             ret_req_o
);
    assert_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_sel_i == '0) |-> !ret_req_o);

    assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_i |-> !ret_req_o);

    assert_sel_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_sel_i != $past(ret_sel_i)) |-> !ret_req_o);

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ret_req_o) && idle_i && (ret_sel_i == $past(ret_sel_i)) && (ret_sel_i != '0))
        |-> ret_req_o);

    assert_rise_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ret_req_o) |-> $past(tick_i));
endmodule

bind ret_idle_ctrl ret_idle_ctrl_chk #(.SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle_i    (idle_i),
    .tick_i    (tick_i),
    .ret_sel_i (ret_sel_i),
    .ret_req_o (ret_req_o)
);

// File: tb/ret_idle_ctrl_tb.sv
module ret_idle_ctrl_tb;
    localparam time CLK_P = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_i = 1'b0;
    logic       tick_i = 1'b0;
    logic [2:0] ret_sel_i = 3'b000;
    logic       ret_req_o;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    // Bench reference state
    int   m_cnt = 0;
    bit   m_req = 1'b0;
    logic [2:0] m_sel = 3'b000;

    always #(CLK_P/2) clk = ~clk;

    ret_idle_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle_i    (idle_i),
        .tick_i    (tick_i),
        .ret_sel_i (ret_sel_i),
        .ret_req_o (ret_req_o)
    );

    // Thresholds per R2 and R3.
    function automatic int thr_of(input logic [2:0] s);
        case (s)
            3'd1: return 2;    3'd2: return 8;    3'd3: return 32;
            3'd4: return 64;   3'd5: return 128;  3'd6: return 256;
            3'd7: return 512;  default: return 0;
        endcase
    endfunction

    function automatic string tag_of(input bit idl, input logic [2:0] s, input logic [2:0] ps);
        if (!idl)      return "R4";
        if (s == 0)    return "R1";
        if (s != ps)   return "R6";
        if (s < 4)     return "R2";
        return "R3";
    endfunction

    task automatic check(input bit got, input bit exp, input string tag);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: ret_req_o=%0b expected %0b (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Drive one cycle, check the output mid-cycle, then advance the reference.
    task automatic step(input bit idl, input bit tk, input logic [2:0] s, input string tag);
        bit clr;
        bit exp;
        @(negedge clk);
        idle_i = idl; tick_i = tk; ret_sel_i = s;
        #1;
        clr = !idl || (s == 0) || (s != m_sel);
        exp = m_req && !clr;
        check(ret_req_o, exp, (tag == "") ? tag_of(idl, s, m_sel) : tag);
        if (clr) begin
            m_cnt = 0; m_req = 1'b0;
        end else begin
            if (tk && m_cnt < 1023) m_cnt++;
            m_req = (m_cnt >= thr_of(s));
        end
        m_sel = s;
    endtask

    initial begin
        #(CLK_P * 300000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state.
        step(1'b1, 1'b0, 3'd0, "R9");
        // R2/R8: shortest threshold, exact tick.
        step(1'b1, 1'b0, 3'd1, "R6");
        step(1'b1, 1'b1, 3'd1, "R9");
        step(1'b1, 1'b1, 3'd1, "R8");
        step(1'b1, 1'b0, 3'd1, "R8");
        // R5: cycles without ticks keep the request and count.
        repeat (20) step(1'b1, 1'b0, 3'd1, "R5");
        // R4: busy cycle drops at once and restarts.
        step(1'b0, 1'b1, 3'd1, "R4");
        step(1'b1, 1'b1, 3'd1, "R4");
        step(1'b1, 1'b0, 3'd1, "R4");
        // R5: ticks absent, no progress toward 8.
        step(1'b1, 1'b0, 3'd2, "R6");
        repeat (50) step(1'b1, 1'b0, 3'd2, "R5");
        // R7: saturation, request held beyond 1023 ticks.
        repeat (1200) step(1'b1, 1'b1, 3'd7, "R7");
        // R1: disable.
        repeat (5) step(1'b1, 1'b1, 3'd0, "R1");
        // R6: change mid-count to a shorter threshold.
        repeat (20) step(1'b1, 1'b1, 3'd3, "R6");
        repeat (5) step(1'b1, 1'b1, 3'd1, "R6");

        // Random phases.
        for (int ph = 0; ph < 90; ph++) begin
            logic [2:0] s = 3'($urandom_range(0, 7));
            int  len = $urandom_range(100, 1300);
            int  tdense = $urandom_range(0, 1);
            for (int c = 0; c < len; c++) begin
                bit idl = ($urandom_range(0, 399) != 0);
                bit tk  = tdense ? ($urandom_range(0, 3) != 0) : ($urandom_range(0, 3) == 0);
                if ($urandom_range(0, 599) == 0) s = 3'($urandom_range(0, 7));
                step(idl, tk, s, "");
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule